// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches a two-wire SMBus clock and data line pair without ever driving them. Both lines pass through a two-stage synchroniser into a free-running system clock. The block recognises START, repeated START and STOP, and it times every clock-low and clock-high interval. From these measurements it reports five kinds of fault:

- a single low interval that runs past the timeout;
- slave clock stretching whose total over one message exceeds its budget;
- master clock stretching whose total over one message exceeds its budget;
- a low phase that is too short;
- a high phase that is too short.

A message is the span from START to STOP. When both lines rest high for longer than the idle threshold during a message, the block gives up on that message and emits a one-cycle transaction-reset pulse. A configuration input turns this idle abandonment off.

The error flags are sticky and are cleared by a clear input. Every threshold is held as a cycle count, computed from a system-clock-frequency parameter and a time parameter. Software or a neighbouring controller drives the attribution input, which says which side is holding the clock low at the moment.

Top module: `smbus_timeout_mon`

## Requirements
- R1: `err_timeout` sets when one uninterrupted clock-low run lasts longer than TIMEOUT_US, which must be configured between 25000 and 35000 µs. A shorter run leaves it clear. This applies inside and outside a message.
- R2: While inside a message and with `slave_ext` high, each low cycle beyond the nominal minimum low period is charged to a slave budget. `err_slave_ext` sets once the total exceeds 25 ms.
- R3: The same charging happens with `slave_ext` low, but it goes to a master budget. `err_master_ext` sets once that total exceeds 10 ms.
- R4: Inside a message, a clock-low run shorter than 4.7 µs, measured at the clock's rising edge, sets `err_low_short`.
- R5: Inside a message, a clock-high run shorter than 4 µs, measured at the clock's falling edge, sets `err_high_short`.
- R6: Inside a message with `idle_rst_dis` low, clock and data both high for more than 50 µs produce exactly one one-cycle `xact_rst` pulse. The message is then abandoned and both extension budgets restart from zero.
- R7: With `idle_rst_dis` high, a long idle produces no `xact_rst` pulse and does not end the message.
- R8: A data fall while the clock is high is a START, and a data rise while the clock is high is a STOP. A STOP clears both extension budgets. A repeated START inside a message does not.
- R9: Every error flag stays set until `err_clr` is high on a clock edge. Synchronous reset (`rst_n` low) clears all flags and `xact_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line (asynchronous) |
| slave_ext | input | 1 | High: current clock stretching is charged to the slave |
| idle_rst_dis | input | 1 | High: long idle does not abandon the message |
| err_clr | input | 1 | Clears all sticky error flags |
| xact_rst | output | 1 | One-cycle transaction-reset pulse |
| err_timeout | output | 1 | Sticky: single low run too long |
| err_slave_ext | output | 1 | Sticky: slave stretch budget exceeded |
| err_master_ext | output | 1 | Sticky: master stretch budget exceeded |
| err_low_short | output | 1 | Sticky: low phase below minimum |
| err_high_short | output | 1 | Sticky: high phase below minimum |

## Verification
The embedded assertions hold on every cycle for these properties:
- the reset pulse lasts one cycle and never appears while the disable input was high;
- flags are sticky;
- a timeout or short-low flag rises only after the matching line state or edge;
- the budgets stay bounded and are zero after a STOP.

Only the directed scenarios can show the rest. That covers the exact thresholds in cycle counts, and the cumulative charging across several low runs. It also covers the contrast between STOP and repeated START, and the clearing of the budgets by an idle abandonment. The bench runs the block with a scaled clock-frequency parameter, so millisecond budgets stay within a short run.

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int TIMEOUT_US    = 30_000,
  parameter int SLV_BUDGET_US = 25_000,
  parameter int MST_BUDGET_US = 10_000,
  parameter int IDLE_NS       = 50_000,
  parameter int LOW_MIN_NS    = 4_700,
  parameter int HIGH_MIN_NS   = 4_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic slave_ext,
  input  logic idle_rst_dis,
  input  logic err_clr,
  output logic xact_rst,
  output logic err_timeout,
  output logic err_slave_ext,
  output logic err_master_ext,
  output logic err_low_short,
  output logic err_high_short
);

  localparam longint HZ    = longint'(CLK_HZ);
  localparam longint TO_C  = (HZ * TIMEOUT_US + 999_999) / 1_000_000;
  localparam longint SLV_C = (HZ * SLV_BUDGET_US + 999_999) / 1_000_000;
  localparam longint MST_C = (HZ * MST_BUDGET_US + 999_999) / 1_000_000;
  localparam longint IDL_C = (HZ * IDLE_NS + 999_999_999) / 1_000_000_000;
  localparam longint LOW_C = (HZ * LOW_MIN_NS + 999_999_999) / 1_000_000_000;
  localparam longint HI_C  = (HZ * HIGH_MIN_NS + 999_999_999) / 1_000_000_000;
  localparam int     CW    = $clog2(TO_C + 2);

  localparam logic [CW-1:0] TO_V   = CW'(TO_C);
  localparam logic [CW-1:0] SLV_V  = CW'(SLV_C);
  localparam logic [CW-1:0] MST_V  = CW'(MST_C);
  localparam logic [CW-1:0] IDLE_V = CW'(IDL_C);
  localparam logic [CW-1:0] LOW_V  = CW'(LOW_C);
  localparam logic [CW-1:0] HI_V   = CW'(HI_C);

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic start, stop, idle_hit, msg_end, in_msg, charge;
  logic [CW-1:0] low_cnt, high_cnt, idle_cnt, slv_acc, mst_acc;
  logic set_to, set_slv, set_mst, set_ls, set_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];

  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign idle_hit = in_msg & scl_s & sda_s & (idle_cnt >= IDLE_V) & ~idle_rst_dis;
  assign msg_end  = stop | idle_hit;
  assign charge   = in_msg & ~scl_s & (low_cnt >= LOW_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      idle_cnt <= '0;
    end else begin
      if (scl_s) begin
        low_cnt  <= '0;
        high_cnt <= (high_cnt == TO_V) ? high_cnt : high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
        low_cnt  <= (low_cnt == TO_V) ? low_cnt : low_cnt + 1'b1;
      end
      if (scl_s && sda_s)
        idle_cnt <= (idle_cnt == IDLE_V) ? idle_cnt : idle_cnt + 1'b1;
      else
        idle_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       in_msg <= 1'b0;
    else if (msg_end) in_msg <= 1'b0;
    else if (start)   in_msg <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || msg_end) begin
      slv_acc <= '0;
      mst_acc <= '0;
    end else if (charge) begin
      if (slave_ext && slv_acc != SLV_V)  slv_acc <= slv_acc + 1'b1;
      if (!slave_ext && mst_acc != MST_V) mst_acc <= mst_acc + 1'b1;
    end
  end

  assign set_to  = ~scl_s & (low_cnt >= TO_V);
  assign set_slv = charge & slave_ext & (slv_acc == SLV_V);
  assign set_mst = charge & ~slave_ext & (mst_acc == MST_V);
  assign set_ls  = in_msg & scl_s & ~scl_q & (low_cnt < LOW_V);
  assign set_hs  = in_msg & ~scl_s & scl_q & (high_cnt < HI_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xact_rst       <= 1'b0;
      err_timeout    <= 1'b0;
      err_slave_ext  <= 1'b0;
      err_master_ext <= 1'b0;
      err_low_short  <= 1'b0;
      err_high_short <= 1'b0;
    end else begin
      xact_rst       <= idle_hit;
      err_timeout    <= (err_timeout & ~err_clr) | set_to;
      err_slave_ext  <= (err_slave_ext & ~err_clr) | set_slv;
      err_master_ext <= (err_master_ext & ~err_clr) | set_mst;
      err_low_short  <= (err_low_short & ~err_clr) | set_ls;
      err_high_short <= (err_high_short & ~err_clr) | set_hs;
    end
  end

  a_r1_timeout_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> !$past(scl_s));
  a_r2_slave_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    slv_acc <= SLV_V);
  a_r3_master_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    mst_acc <= MST_V);
  a_r4_short_low_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_low_short) |-> $past(scl_s && !scl_q));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xact_rst |=> !xact_rst);
  a_r7_no_pulse_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    xact_rst |-> !$past(idle_rst_dis));
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) |-> (slv_acc == '0 && mst_acc == '0 && !in_msg));
  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_timeout && !err_clr) |=> err_timeout);
  a_r9_master_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_master_ext && !err_clr) |=> err_master_ext);

endmodule

// File: tb/test_smbus_timeout_mon.sv
module test_smbus_timeout_mon;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic slave_ext = 1'b0, idle_rst_dis = 1'b0, err_clr = 1'b0;
  logic xact_rst, err_timeout, err_slave_ext, err_master_ext, err_low_short, err_high_short;
  int checks = 0, errors = 0, pulses = 0;

  always #5 clk = ~clk;

  smbus_timeout_mon #(.CLK_HZ(1_000_000)) i_smbus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .slave_ext(slave_ext), .idle_rst_dis(idle_rst_dis), .err_clr(err_clr),
    .xact_rst(xact_rst), .err_timeout(err_timeout), .err_slave_ext(err_slave_ext),
    .err_master_ext(err_master_ext), .err_low_short(err_low_short),
    .err_high_short(err_high_short));

  always @(negedge clk) if (rst_n && xact_rst) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic d, input int n);
    scl = c;
    sda = d;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic clear_flags();
    err_clr = 1'b1;
    @(posedge clk);
    #2;
    err_clr = 1'b0;
    settle();
  endtask

  task automatic msg_start();
    bus(1, 1, 20); bus(1, 0, 20); bus(0, 0, 20);
  endtask

  task automatic msg_stop();
    bus(0, 0, 20); bus(1, 0, 20); bus(1, 1, 20);
  endtask

  task automatic t_reset();
    settle();
    check("R9 reset xact_rst", xact_rst, 0);
    check("R9 reset flags", {err_timeout, err_slave_ext, err_master_ext,
          err_low_short, err_high_short}, 0);
  endtask

  task automatic t_normal();
    msg_start();
    for (int i = 0; i < 9; i++) begin
      bus(0, i[0], 10); bus(1, i[0], 10);
    end
    msg_stop();
    settle();
    check("R8 clean message no errors", {err_timeout, err_slave_ext, err_master_ext,
          err_low_short, err_high_short}, 0);
    check("R6 no pulse outside message", pulses, 0);
  endtask

  task automatic t_short_low();
    msg_start();
    bus(0, 1, 10); bus(1, 1, 10);
    bus(0, 1, 3); bus(1, 1, 10);
    msg_stop();
    settle();
    check("R4 short low flagged", err_low_short, 1);
    check("R4 no high-short", err_high_short, 0);
    clear_flags();
    check("R9 clear drops flag", err_low_short, 0);
  endtask

  task automatic t_short_high();
    msg_start();
    bus(0, 0, 10); bus(1, 0, 2); bus(0, 0, 10);
    msg_stop();
    settle();
    check("R5 short high flagged", err_high_short, 1);
    check("R5 no low-short", err_low_short, 0);
    clear_flags();
  endtask

  task automatic t_timeout();
    bus(0, 1, 20000); bus(1, 1, 20);
    settle();
    check("R1 20 ms low no timeout", err_timeout, 0);
    bus(0, 1, 30010); bus(1, 1, 20);
    settle();
    check("R1 timeout flagged", err_timeout, 1);
    check("R2 outside message no slave charge", err_slave_ext, 0);
    bus(1, 1, 50);
    check("R9 timeout stays set", err_timeout, 1);
    clear_flags();
    check("R9 timeout cleared", err_timeout, 0);
  endtask

  task automatic t_slave();
    slave_ext = 1'b1;
    msg_start();
    bus(0, 1, 9000); bus(1, 1, 10);
    bus(0, 1, 9000); bus(1, 1, 10);
    settle();
    check("R2 below slave budget", err_slave_ext, 0);
    bus(0, 1, 9000); bus(1, 1, 10);
    settle();
    check("R2 slave budget exceeded", err_slave_ext, 1);
    check("R3 master untouched by slave stretch", err_master_ext, 0);
    check("R1 no timeout on 9 ms lows", err_timeout, 0);
    msg_stop();
    slave_ext = 1'b0;
    clear_flags();
  endtask

  task automatic t_master();
    msg_start();
    bus(0, 1, 6000); bus(1, 1, 10);
    settle();
    check("R3 below master budget", err_master_ext, 0);
    bus(0, 1, 6000); bus(1, 1, 10);
    settle();
    check("R3 master budget exceeded", err_master_ext, 1);
    check("R2 slave untouched by master stretch", err_slave_ext, 0);
    msg_stop();
    clear_flags();
  endtask

  task automatic t_stop_vs_restart();
    msg_start();
    bus(0, 1, 6000);
    msg_stop();
    msg_start();
    bus(0, 1, 6000);
    msg_stop();
    settle();
    check("R8 stop clears budget", err_master_ext, 0);
    msg_start();
    bus(0, 1, 6000);
    bus(1, 1, 20); bus(1, 0, 20); bus(0, 0, 20);
    bus(0, 1, 6000);
    msg_stop();
    settle();
    check("R8 repeated start keeps budget", err_master_ext, 1);
    clear_flags();
  endtask

  task automatic t_idle();
    int p0;
    p0 = pulses;
    msg_start();
    bus(0, 1, 20); bus(1, 1, 100);
    check("R6 one reset pulse", pulses - p0, 1);
    p0 = pulses;
    idle_rst_dis = 1'b1;
    msg_start();
    bus(0, 1, 20); bus(1, 1, 100);
    check("R7 disabled idle no pulse", pulses - p0, 0);
    msg_stop();
    idle_rst_dis = 1'b0;
    bus(1, 1, 100);
    check("R7 idle after stop no pulse", pulses - p0, 0);
    msg_start();
    bus(0, 1, 6000); bus(1, 1, 100);
    msg_start();
    bus(0, 1, 6000);
    msg_stop();
    settle();
    check("R6 idle reset clears budget", err_master_ext, 0);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_short_low();
    t_short_high();
    t_timeout();
    t_slave();
    t_master();
    t_stop_vs_restart();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule